// File: doc/BRIEF.md
# Variable-Width Digit Splitter and Carry Releaser

This block sits beside a weighted-transform squaring engine that works on residues modulo the Mersenne number M = 2^q - 1. Its forward path takes a q-bit residue and emits N digits of unequal width, one per cycle, lowest digit first. The digit widths are picked so that N digits, with N a power of two, cover exactly q bits whatever q is. The exponent q is given at run time and may be anything from N up to the parameter QMAX.

The reverse path rebuilds a residue from N digits that come back from the transform. These digits are signed and may be wider than their slots. The path accepts one digit per cycle and releases carries upward from digit to digit. The carry out of the top digit is wrapped back into the low end, since 2^q ≡ 1 (mod M). Folding continues until the value lies inside q bits, and the result is given in canonical form in the range 0..M-1.

Both paths are independent and may run in the same cycles. A digit stream from the forward path can be fed straight back into the reverse path.

Top module: `vb_digit_unit`

## Requirements
- R1: While rst_ni is low and on the first cycle after its release, digit_valid_o and res_valid_o are 0.
- R2: Digit j starts at bit offset ceil(q*j/N) and is ceil(q*(j+1)/N) - ceil(q*j/N) bits wide. digit_o carries those bits of the residue, zero-extended. For q = 37 and N = 4 the widths are 10, 9, 9, 9, and 78,314,567,209 gives 553, 93, 381, 291.
- R3: When split_start_i is high at an edge with no split in progress, digit_valid_o is high for exactly N consecutive cycles starting in the next cycle. digit_idx_o counts 0..N-1 over those cycles.
- R4: A split_start_i pulse that arrives while a split is streaming is ignored. The digits in progress are unchanged and no extra digits follow.
- R5: Bits of split_val_i at positions q and above are ignored by the splitter.
- R6: N rb_valid_i beats deliver digits 0..N-1 in order, and q is sampled on the first beat. After them, res_valid_o pulses for one cycle with res_o = (sum of digit_j * 2^offset_j) mod (2^q - 1).
- R7: A digit that exceeds its slot width passes its excess as a carry into the next digit.
- R8: The carry out of digit N-1 is added back into the low end, so weight 2^q counts as 1.
- R9: Digits are two's-complement signed, and negative digits borrow from the digits above. A negative total wraps to its positive residue.
- R10: A total congruent to 2^q - 1 is reported as 0, so res_o is always below 2^q - 1.
- R11: A split and a rebuild may run in the same cycles without disturbing each other. Looping digit_o into rb_digit_i returns the q-bit input residue in canonical form.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| split_start_i | input | 1 | Start a split |
| split_q_i | input | QW | Exponent q for the split |
| split_val_i | input | QMAX | Residue to split |
| digit_valid_o | output | 1 | Digit output valid |
| digit_idx_o | output | IW | Index of the current digit |
| digit_o | output | DWMAX | Current digit, zero-extended |
| rb_valid_i | input | 1 | Rebuild digit beat |
| rb_q_i | input | QW | Exponent q, sampled on digit 0 |
| rb_digit_i | input | DW | Signed digit to rebuild |
| res_valid_o | output | 1 | One-cycle pulse: result ready |
| res_o | output | QMAX | Canonical rebuilt residue |

## Verification
The splitter streaming digits and the carry releaser absorbing digits can fall in the same cycle. This is provoked by wiring each digit the bench samples from digit_o back into rb_digit_i on the same cycle, for random q and random values. While digit j+1 is being emitted, digit j is entering the carry chain. Each such run is judged twice: every emitted digit is compared with a bench model of the offset and width rule, and the rebuilt residue must equal the masked input reduced to canonical form.

// File: rtl/vb_pkg.sv
package vb_pkg;
  typedef enum logic {SPL_IDLE, SPL_RUN} spl_state_e;
endpackage

// File: rtl/vb_geom.sv
module vb_geom #(
  parameter int N  = 4,
  parameter int QW = 7,
  parameter int IW = 2
) (
  input  logic [QW-1:0] q_i,
  input  logic [IW-1:0] idx_i,
  output logic [QW-1:0] off_o,
  output logic [QW-1:0] wid_o
);
  localparam int PW = QW + IW + 1;
  logic [PW-1:0] lo_p, hi_p, lo_c, hi_c;

  // ceil(q*j/N) with N a power of two
  always_comb begin
    lo_p  = PW'(q_i) * PW'(idx_i) + PW'(N - 1);
    hi_p  = PW'(q_i) * (PW'(idx_i) + PW'(1)) + PW'(N - 1);
    lo_c  = lo_p >> IW;
    hi_c  = hi_p >> IW;
    off_o = QW'(lo_c);
    wid_o = QW'(hi_c - lo_c);
  end
endmodule

// File: rtl/vb_splitter.sv
module vb_splitter #(
  parameter int N     = 4,
  parameter int QMAX  = 64,
  parameter int QW    = 7,
  parameter int IW    = 2,
  parameter int DWMAX = 16
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             start_i,
  input  logic [QW-1:0]    q_i,
  input  logic [QMAX-1:0]  val_i,
  output logic             valid_o,
  output logic [IW-1:0]    idx_o,
  output logic [DWMAX-1:0] digit_o
);
  import vb_pkg::*;

  spl_state_e      st_q;
  logic [QW-1:0]   q_r;
  logic [QMAX-1:0] val_r;
  logic [IW-1:0]   idx_r;
  logic [QW-1:0]   off, wid;
  logic [QMAX-1:0] in_mask, shv, dmask;

  vb_geom #(.N(N), .QW(QW), .IW(IW)) u_geom (
    .q_i(q_r), .idx_i(idx_r), .off_o(off), .wid_o(wid)
  );

  assign in_mask = (QMAX'(1) << q_i) - QMAX'(1);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      st_q  <= SPL_IDLE;
      q_r   <= '0;
      val_r <= '0;
      idx_r <= '0;
    end else begin
      case (st_q)
        SPL_IDLE: if (start_i) begin
          val_r <= val_i & in_mask;
          q_r   <= q_i;
          idx_r <= '0;
          st_q  <= SPL_RUN;
        end
        default: begin
          idx_r <= idx_r + IW'(1);
          if (idx_r == IW'(N - 1)) st_q <= SPL_IDLE;
        end
      endcase
    end
  end

  always_comb begin
    shv     = val_r >> off;
    dmask   = (QMAX'(1) << wid) - QMAX'(1);
    digit_o = DWMAX'(shv & dmask);
  end

  assign valid_o = (st_q == SPL_RUN);
  assign idx_o   = idx_r;
endmodule

// File: rtl/vb_carry_release.sv
module vb_carry_release #(
  parameter int N    = 4,
  parameter int QMAX = 64,
  parameter int QW   = 7,
  parameter int IW   = 2,
  parameter int DW   = 24,
  parameter int VW   = 66
) (
  input  logic                 clk_i,
  input  logic                 rst_ni,
  input  logic                 valid_i,
  input  logic [QW-1:0]        q_i,
  input  logic signed [DW-1:0] digit_i,
  output logic                 load_o,
  output logic signed [VW-1:0] v_o,
  output logic [QW-1:0]        q_o
);
  localparam int TW = DW + 2;

  logic [IW-1:0]        cnt_r;
  logic [QW-1:0]        q_r, q_eff;
  logic [QMAX-1:0]      r_r, r_eff, r_new;
  logic signed [DW:0]   c_r, c_eff, c_new;
  logic signed [TW-1:0] t, c_wide;
  logic [TW-1:0]        tmask, low;
  logic [QW-1:0]        off, wid;
  logic signed [VW-1:0] v_new;
  logic                 first;

  vb_geom #(.N(N), .QW(QW), .IW(IW)) u_geom (
    .q_i(q_eff), .idx_i(cnt_r), .off_o(off), .wid_o(wid)
  );

  always_comb begin
    first  = (cnt_r == '0);
    q_eff  = first ? q_i : q_r;
    r_eff  = first ? '0 : r_r;
    c_eff  = first ? '0 : c_r;
    t      = $signed({{2{digit_i[DW-1]}}, digit_i}) + $signed({c_eff[DW], c_eff});
    tmask  = (TW'(1) << wid) - TW'(1);
    low    = t & tmask;
    c_wide = t >>> wid;           // floor division keeps borrows exact
    c_new  = c_wide[DW:0];
    r_new  = r_eff | (QMAX'(low) << off);
    v_new  = $signed({2'b00, r_new}) + $signed({{(VW-DW-1){c_new[DW]}}, c_new});
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cnt_r  <= '0;
      q_r    <= '0;
      r_r    <= '0;
      c_r    <= '0;
      load_o <= 1'b0;
      v_o    <= '0;
    end else begin
      load_o <= 1'b0;
      if (valid_i) begin
        cnt_r <= cnt_r + IW'(1);
        q_r   <= q_eff;
        r_r   <= r_new;
        c_r   <= c_new;
        if (cnt_r == IW'(N - 1)) begin
          load_o <= 1'b1;
          v_o    <= v_new;
        end
      end
    end
  end

  assign q_o = q_r;
endmodule

// File: rtl/vb_mersenne_fold.sv
module vb_mersenne_fold #(
  parameter int QMAX = 64,
  parameter int QW   = 7,
  parameter int VW   = 66
) (
  input  logic                 clk_i,
  input  logic                 rst_ni,
  input  logic                 load_i,
  input  logic signed [VW-1:0] v_i,
  input  logic [QW-1:0]        q_i,
  output logic                 res_valid_o,
  output logic [QMAX-1:0]      res_o
);
  logic signed [VW-1:0] v_r, lo_part, hi_part, nxt;
  logic [VW-1:0]        qmask;
  logic [QW-1:0]        q_r;
  logic                 busy_r, in_range;

  always_comb begin
    qmask    = (VW'(1) << q_r) - VW'(1);
    lo_part  = $signed(v_r & qmask);
    hi_part  = v_r >>> q_r;        // 2^q == 1 mod M
    nxt      = lo_part + hi_part;
    in_range = !v_r[VW-1] && ((v_r >> q_r) == '0);
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      v_r         <= '0;
      q_r         <= '0;
      busy_r      <= 1'b0;
      res_valid_o <= 1'b0;
      res_o       <= '0;
    end else begin
      res_valid_o <= 1'b0;
      if (load_i) begin
        v_r    <= v_i;
        q_r    <= q_i;
        busy_r <= 1'b1;
      end else if (busy_r) begin
        if (in_range) begin
          busy_r      <= 1'b0;
          res_valid_o <= 1'b1;
          res_o       <= ($unsigned(v_r) == qmask) ? '0 : v_r[QMAX-1:0];
        end else begin
          v_r <= nxt;
        end
      end
    end
  end
endmodule

// File: rtl/vb_digit_unit.sv
module vb_digit_unit #(
  parameter  int N     = 4,
  parameter  int QMAX  = 64,
  parameter  int DW    = 24,
  localparam int IW    = $clog2(N),
  localparam int QW    = $clog2(QMAX + 1),
  localparam int DWMAX = (QMAX + N - 1) / N,
  localparam int VW    = QMAX + 2
) (
  input  logic                 clk_i,
  input  logic                 rst_ni,
  input  logic                 split_start_i,
  input  logic [QW-1:0]        split_q_i,
  input  logic [QMAX-1:0]      split_val_i,
  output logic                 digit_valid_o,
  output logic [IW-1:0]        digit_idx_o,
  output logic [DWMAX-1:0]     digit_o,
  input  logic                 rb_valid_i,
  input  logic [QW-1:0]        rb_q_i,
  input  logic signed [DW-1:0] rb_digit_i,
  output logic                 res_valid_o,
  output logic [QMAX-1:0]      res_o
);
  logic                 load;
  logic signed [VW-1:0] v_load;
  logic [QW-1:0]        q_load;

  vb_splitter #(.N(N), .QMAX(QMAX), .QW(QW), .IW(IW), .DWMAX(DWMAX)) u_split (
    .clk_i, .rst_ni,
    .start_i(split_start_i), .q_i(split_q_i), .val_i(split_val_i),
    .valid_o(digit_valid_o), .idx_o(digit_idx_o), .digit_o(digit_o)
  );

  vb_carry_release #(.N(N), .QMAX(QMAX), .QW(QW), .IW(IW), .DW(DW), .VW(VW)) u_carry (
    .clk_i, .rst_ni,
    .valid_i(rb_valid_i), .q_i(rb_q_i), .digit_i(rb_digit_i),
    .load_o(load), .v_o(v_load), .q_o(q_load)
  );

  vb_mersenne_fold #(.QMAX(QMAX), .QW(QW), .VW(VW)) u_fold (
    .clk_i, .rst_ni,
    .load_i(load), .v_i(v_load), .q_i(q_load),
    .res_valid_o, .res_o
  );
endmodule

// File: rtl/vb_digit_unit_chk.sv
module vb_digit_unit_chk #(
  parameter int N  = 4,
  parameter int IW = 2
) (
  input logic          clk_i,
  input logic          rst_ni,
  input logic          digit_valid_o,
  input logic [IW-1:0] digit_idx_o,
  input logic          res_valid_o
);
  logic [IW+1:0] run_r;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)            run_r <= '0;
    else if (!digit_valid_o) run_r <= '0;
    else                    run_r <= run_r + (IW+2)'(1);
  end

  // R1
  reset_quiet_chk: assert property (@(posedge clk_i)
    !rst_ni |=> !digit_valid_o && !res_valid_o);
  // R3
  run_len_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    digit_valid_o |-> run_r < (IW+2)'(N));
  // R3
  run_end_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(digit_valid_o) |-> run_r == (IW+2)'(N));
  // R3
  first_idx_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(digit_valid_o) |-> digit_idx_o == '0);
  // R3
  idx_step_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    digit_valid_o && $past(digit_valid_o) |-> digit_idx_o == $past(digit_idx_o) + IW'(1));
  // R6
  res_pulse_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    res_valid_o |=> !res_valid_o);
endmodule

bind vb_digit_unit vb_digit_unit_chk #(.N(N), .IW(IW)) u_chk (
  .clk_i(clk_i), .rst_ni(rst_ni), .digit_valid_o(digit_valid_o),
  .digit_idx_o(digit_idx_o), .res_valid_o(res_valid_o)
);

// File: tb/vb_digit_unit_bench.sv
`timescale 1ns/1ps
module vb_digit_unit_bench;
  localparam int N = 4, QMAX = 64, DW = 24, IW = 2, QW = 7, DWMAX = 16;

  typedef struct packed {
    logic [6:0]       q;
    logic [63:0]      val;
    logic [3:0][15:0] dig;
  } vec_t;

  // R2 / R5 / R10 vectors, digit 0 in the low slot
  localparam vec_t VECS [5] = '{
    '{q: 7'd37, val: 64'd78314567209,          dig: {16'd291, 16'd381, 16'd93, 16'd553}},
    '{q: 7'd8,  val: 64'd180,                  dig: {16'd2, 16'd3, 16'd1, 16'd0}},
    '{q: 7'd5,  val: 64'd22,                   dig: {16'd1, 16'd0, 16'd1, 16'd2}},
    '{q: 7'd13, val: 64'hFFFF_0000_0000_1ABC,  dig: {16'd6, 16'd5, 16'd3, 16'd12}},
    '{q: 7'd64, val: 64'hFFFF_FFFF_FFFF_FFFF,  dig: {16'hFFFF, 16'hFFFF, 16'hFFFF, 16'hFFFF}}
  };

  logic clk_i = 1'b0, rst_ni = 1'b0;
  logic split_start_i = 1'b0, rb_valid_i = 1'b0;
  logic [QW-1:0] split_q_i = '0, rb_q_i = '0;
  logic [QMAX-1:0] split_val_i = '0;
  logic signed [DW-1:0] rb_digit_i = '0;
  logic digit_valid_o, res_valid_o;
  logic [IW-1:0] digit_idx_o;
  logic [DWMAX-1:0] digit_o;
  logic [QMAX-1:0] res_o;
  int checks = 0, errors = 0;

  always #2.5 clk_i = ~clk_i;

  vb_digit_unit u_vb_digit_unit (.*);

  task automatic check(input bit ok, input string req, input logic [127:0] act, input logic [127:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  function automatic int off_of(int q, int j);
    return (q * j + N - 1) / N;
  endfunction

  function automatic logic [63:0] qmask(int q);
    return (q >= 64) ? '1 : ((64'd1 << q) - 64'd1);
  endfunction

  function automatic logic [63:0] mmod(logic signed [127:0] s, int q);
    logic signed [127:0] m, r;
    m = (128'sd1 <<< q) - 128'sd1;
    r = s % m;
    if (r < 0) r = r + m;
    return r[63:0];
  endfunction

  function automatic logic [63:0] model_sum(int q, int d0, int d1, int d2, int d3);
    logic signed [127:0] s, t;
    int d [4];
    d = '{d0, d1, d2, d3};
    s = 0;
    for (int j = 0; j < N; j++) begin
      t = d[j];
      s = s + (t <<< off_of(q, j));
    end
    return mmod(s, q);
  endfunction

  task automatic wait_res(input logic [63:0] exp, input string req);
    bit got = 0;
    for (int k = 0; k < 80 && !got; k++) begin
      if (res_valid_o) begin
        got = 1;
        check(res_o == exp, req, res_o, exp);
      end else @(negedge clk_i);
    end
    if (!got) check(0, {req, " no result"}, 0, exp);
  endtask

  task automatic rebuild(input int q, input int d0, d1, d2, d3, input logic [63:0] exp, input string req);
    int d [4];
    d = '{d0, d1, d2, d3};
    for (int j = 0; j < N; j++) begin
      @(negedge clk_i);
      rb_valid_i = 1'b1; rb_q_i = QW'(q); rb_digit_i = DW'(d[j]);
    end
    @(negedge clk_i);
    rb_valid_i = 1'b0;
    wait_res(exp, req);
  endtask

  // split, optionally looping each digit into the rebuild port in the same cycle
  task automatic split_run(input int q, input logic [63:0] val, input bit loopback,
                           output logic [3:0][15:0] dig);
    @(negedge clk_i);
    split_start_i = 1'b1; split_q_i = QW'(q); split_val_i = val;
    @(negedge clk_i);
    split_start_i = 1'b0;
    for (int j = 0; j < N; j++) begin
      check(digit_valid_o && digit_idx_o == IW'(j), "R3 valid/idx", {digit_valid_o, digit_idx_o}, {1'b1, 2'(j)});
      dig[j] = digit_o;
      rb_valid_i = loopback; rb_q_i = QW'(q); rb_digit_i = DW'(digit_o);
      @(negedge clk_i);
    end
    rb_valid_i = 1'b0;
    check(!digit_valid_o, "R3 stream ends after N", digit_valid_o, 0);
  endtask

  initial begin
    repeat (100000) @(posedge clk_i);
    errors++; checks++;
    $display("FAIL watchdog expired actual=0 expected=1");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    logic [3:0][15:0] dig;
    repeat (3) @(negedge clk_i);
    check(!digit_valid_o && !res_valid_o, "R1 reset outputs", {digit_valid_o, res_valid_o}, 0);
    rst_ni = 1'b1;
    @(negedge clk_i);
    check(!digit_valid_o && !res_valid_o, "R1 after release", {digit_valid_o, res_valid_o}, 0);

    // table walk: split digits, then rebuild from the table digits
    for (int i = 0; i < 5; i++) begin
      split_run(VECS[i].q, VECS[i].val, 1'b0, dig);
      for (int j = 0; j < N; j++)
        check(dig[j] == VECS[i].dig[j], (i == 3) ? "R5 high bits ignored" : "R2 digit", dig[j], VECS[i].dig[j]);
      rebuild(VECS[i].q, VECS[i].dig[0], VECS[i].dig[1], VECS[i].dig[2], VECS[i].dig[3],
              (i == 4) ? 64'd0 : (VECS[i].val & qmask(VECS[i].q)), (i == 4) ? "R10 canonical zero" : "R6 rebuild");
    end

    // R4: second start during streaming is ignored
    @(negedge clk_i);
    split_start_i = 1'b1; split_q_i = 7'd8; split_val_i = 64'd180;
    @(negedge clk_i);
    split_q_i = 7'd8; split_val_i = 64'd255;
    for (int j = 0; j < N; j++) begin
      check(digit_valid_o && digit_o == VECS[1].dig[j], "R4 restart ignored", digit_o, VECS[1].dig[j]);
      @(negedge clk_i);
      split_start_i = 1'b0;
    end
    check(!digit_valid_o, "R4 no extra digits", digit_valid_o, 0);

    // carry and borrow corner cases
    rebuild(8, 5, 0, 0, 0, 64'd5, "R7 carry into next digit");
    rebuild(8, 3, 3, 3, 4, 64'd64, "R8 top carry wraps");
    rebuild(8, -1, 0, 0, 0, 64'd254, "R9 negative wraps");
    rebuild(8, 0, -1, 0, 1, 64'd60, "R9 borrow");
    rebuild(37, -1000, 5000, -3, 70000, model_sum(37, -1000, 5000, -3, 70000), "R9 mixed signs q37");
    rebuild(4, -4194304, 0, 0, 0, model_sum(4, -4194304, 0, 0, 0), "R9 deep borrow q4");
    rebuild(8, 255, 0, 0, 0, 64'd0, "R10 multiple of M");

    // R11: split and rebuild share cycles through loopback
    for (int n = 0; n < 20; n++) begin
      int q;
      logic [63:0] val, valm;
      q = 4 + int'($urandom % 61);
      val = {$urandom, $urandom};
      valm = val & qmask(q);
      split_run(q, val, 1'b1, dig);
      for (int j = 0; j < N; j++) begin
        logic [63:0] ed;
        ed = (valm >> off_of(q, j)) & qmask(off_of(q, j + 1) - off_of(q, j));
        check(dig[j] == ed[15:0], "R2 random digit", dig[j], ed);
      end
      wait_res(mmod($signed({64'd0, valm}), q), "R11 loopback round trip");
    end

    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule